// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from identical 4-bit slices. Each slice can be cleared or preset with a parallel value and has two count-enable inputs. Only one of the two enables, the carry-enable, takes part in forming the terminal-count carry. Slices chain through that carry, so a two-slice build counts through all 256 states of an 8-bit value. The carry takes no extra clock cycle, because it is formed combinationally from the count.

A wrap controller sits between the ports and the slices. A parameter selects one of three ways to close the count sequence:

- Plain binary wrap.
- Reload: at the all-ones state the counter loads a preset of 2^W minus the modulus, so with a modulus of 11 on one slice it runs 5 through 15.
- Decode-clear: when the count reaches modulus minus one the counter clears itself, so it runs 0 through 10.

Every change of state, including clear and load, happens on the rising clock edge.

Top module: `presettable_counter`

## Requirements
- R1: A high `clr` forces `count` to 0 at the next rising edge, whatever `load`, `en_p`, `en_t` and `din` hold.
- R2: With `clr` low and `load` high, `count` takes the value of `din` at the next edge, whatever the enables hold.
- R3: With `clr` and `load` low and both `en_p` and `en_t` high, `count` rises by one per edge. In binary mode it wraps from all ones to 0.
- R4: With `clr` and `load` low and either enable low, `count` keeps its value.
- R5: In binary and reload modes, `carry_out` is high exactly when `en_t` is high and `count` is all ones. It does not depend on `en_p` and it changes without waiting for a clock edge.
- R6: Slices cascade. A slice's carry drives the next slice's carry-enable, while `en_p` reaches every slice. For example, an 8-bit count steps from 0x0F to 0x10, and it returns to its start after 256 enabled edges.
- R7: In reload mode with modulus M, an enabled edge at the all-ones count loads 2^W − M. With W = 4 and M = 11 the sequence after clear is 0, 1, …, 15, 5, 6, …, 15, 5.
- R8: In decode-clear mode with modulus M, an enabled edge at count M − 1 clears to 0, and `carry_out` is high when `en_t` is high and `count` equals M − 1. With M = 11 the count runs 0 to 10 and repeats.
- R9: When the modulus wrap and a user `load` fall on the same edge, the user `load` wins and `count` takes `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| load | input | 1 | Synchronous parallel preset, active high |
| en_p | input | 1 | Count enable that is not part of the carry |
| en_t | input | 1 | Count enable that also qualifies the carry |
| din | input | STAGE_W*STAGES | Parallel preset value |
| count | output | STAGE_W*STAGES | Registered count |
| carry_out | output | 1 | Terminal-count carry for further cascading |

## Verification
The bench provokes two collisions in the same clock edge.

- **Clear and load together.** The bench asserts both with a nonzero preset and expects 0.
- **User load and the modulus wrap together.** The reload-mode counter is walked to 15 and the decode-clear counter is preset to 10. Each then receives a `load` with its enables high on that edge, so the wrap would otherwise fire. The count must equal the loaded value rather than 5 or 0.

The bench also steps both modulus builds through more than two full periods against a reference sequence computed in the bench.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    MOD_BINARY = 2'd0,
    MOD_RELOAD = 2'd1,
    MOD_DECODE = 2'd2
  } wrap_mode_e;

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         rco
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (clr)                q <= '0;
    else if (load)          q <= din;
    else if (en_p && en_t)  q <= q + 1'b1;
  end

  assign rco = en_t && (q == ALL_ONES);

  // R1: clear lands on the following edge
  p_clear_zero_r1: assert property (@(posedge clk) $past(clr) |-> (q == '0));

  // R2: load beats counting
  p_load_value_r2: assert property (@(posedge clk) disable iff (clr)
    load |=> (q == $past(din)));

  // R3: enabled slice steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (clr)
    (!load && en_p && en_t) |=> (q == $past(q) + 1'b1));

  // R4: any low enable holds the slice
  p_hold_r4: assert property (@(posedge clk) disable iff (clr)
    (!load && !(en_p && en_t)) |=> $stable(q));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int unsigned STAGE_W = 4,
  parameter int unsigned STAGES  = 2
) (
  input  logic                        clk,
  input  logic                        clr,
  input  logic                        load,
  input  logic                        en_p,
  input  logic                        en_t,
  input  logic [STAGE_W*STAGES-1:0]   din,
  output logic [STAGE_W*STAGES-1:0]   q,
  output logic                        carry
);

  localparam int unsigned TW = STAGE_W * STAGES;

  logic [STAGES-1:0] rco_v;
  logic [STAGES-1:0] ent_v;

  for (genvar i = 0; i < STAGES; i++) begin : g_slice
    if (i == 0) begin : g_first
      assign ent_v[i] = en_t;
    end else begin : g_next
      assign ent_v[i] = rco_v[i-1];
    end

    cnt_stage #(.W(STAGE_W)) u_slice (
      .clk  (clk),
      .clr  (clr),
      .load (load),
      .en_p (en_p),
      .en_t (ent_v[i]),
      .din  (din[i*STAGE_W +: STAGE_W]),
      .q    (q[i*STAGE_W +: STAGE_W]),
      .rco  (rco_v[i])
    );
  end

  assign carry = rco_v[STAGES-1];

  // R6: full-width all-ones with enables wraps to zero across slices
  p_cascade_wrap_r6: assert property (@(posedge clk) disable iff (clr)
    (!load && en_p && en_t && (q == {TW{1'b1}})) |=> (q == '0));

  // R5: chain carry only with carry-enable and full count
  p_carry_term_r5: assert property (@(posedge clk) disable iff (clr)
    carry |-> (en_t && (q == {TW{1'b1}})));

endmodule

// File: rtl/cnt_wrap_ctrl.sv
module cnt_wrap_ctrl #(
  parameter int unsigned          W       = 8,
  parameter cnt_pkg::wrap_mode_e  MODE    = cnt_pkg::MOD_BINARY,
  parameter int unsigned          MODULUS = 256
) (
  input  logic         clr,
  input  logic         load,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  input  logic [W-1:0] q,
  input  logic         chain_carry,
  output logic         clr_eff,
  output logic         load_eff,
  output logic [W-1:0] din_eff,
  output logic         carry
);

  localparam int unsigned  SPAN    = 1 << W;
  localparam logic [W-1:0] PRESET  = W'(SPAN - MODULUS);
  localparam logic [W-1:0] LAST    = W'(MODULUS - 1);
  localparam bit           IS_REL  = (MODE == cnt_pkg::MOD_RELOAD);
  localparam bit           IS_DEC  = (MODE == cnt_pkg::MOD_DECODE);

  logic dec_hit;
  logic wrap_now;

  assign dec_hit  = (q == LAST);
  assign wrap_now = IS_DEC ? (en_p && en_t && dec_hit) : (en_p && chain_carry);

  assign clr_eff  = clr || (IS_DEC && wrap_now && !load);
  assign load_eff = load || (IS_REL && wrap_now);
  assign din_eff  = load ? din : PRESET;
  assign carry    = IS_DEC ? (en_t && dec_hit) : chain_carry;

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter #(
  parameter int unsigned         STAGE_W = 4,
  parameter int unsigned         STAGES  = 2,
  parameter cnt_pkg::wrap_mode_e MODE    = cnt_pkg::MOD_BINARY,
  parameter int unsigned         MODULUS = 256
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      load,
  input  logic                      en_p,
  input  logic                      en_t,
  input  logic [STAGE_W*STAGES-1:0] din,
  output logic [STAGE_W*STAGES-1:0] count,
  output logic                      carry_out
);

  localparam int unsigned  TW     = STAGE_W * STAGES;
  localparam int unsigned  SPAN   = 1 << TW;
  localparam logic [TW-1:0] PRESET = TW'(SPAN - MODULUS);
  localparam logic [TW-1:0] LAST   = TW'(MODULUS - 1);

  logic          clr_eff;
  logic          load_eff;
  logic [TW-1:0] din_eff;
  logic          chain_carry;

  cnt_wrap_ctrl #(.W(TW), .MODE(MODE), .MODULUS(MODULUS)) u_wrap (
    .clr         (clr),
    .load        (load),
    .en_p        (en_p),
    .en_t        (en_t),
    .din         (din),
    .q           (count),
    .chain_carry (chain_carry),
    .clr_eff     (clr_eff),
    .load_eff    (load_eff),
    .din_eff     (din_eff),
    .carry       (carry_out)
  );

  cnt_chain #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_chain (
    .clk   (clk),
    .clr   (clr_eff),
    .load  (load_eff),
    .en_p  (en_p),
    .en_t  (en_t),
    .din   (din_eff),
    .q     (count),
    .carry (chain_carry)
  );

  // R9: a user load always sets the count to din
  p_user_load_r9: assert property (@(posedge clk) disable iff (clr)
    load |=> (count == $past(din)));

  if (MODE == cnt_pkg::MOD_RELOAD) begin : g_rel_chk
    // R7: terminal count reloads the preset
    p_reload_r7: assert property (@(posedge clk) disable iff (clr)
      (!load && en_p && en_t && (count == {TW{1'b1}})) |=> (count == PRESET));
  end else if (MODE == cnt_pkg::MOD_DECODE) begin : g_dec_chk
    // R8: last state clears the count
    p_decode_clear_r8: assert property (@(posedge clk) disable iff (clr)
      (!load && en_p && en_t && (count == LAST)) |=> (count == '0));
  end

endmodule

// File: tb/presettable_counter_tb.sv
module presettable_counter_tb;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       load = 1'b0;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] cnt8;
  logic       c8;
  logic [3:0] cnt_rel, cnt_dec;
  logic       c_rel, c_dec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  presettable_counter #(.STAGE_W(4), .STAGES(2), .MODE(cnt_pkg::MOD_BINARY), .MODULUS(256)) u_dut (
    .clk(clk), .clr(clr), .load(load), .en_p(en_p), .en_t(en_t),
    .din(din), .count(cnt8), .carry_out(c8));

  presettable_counter #(.STAGE_W(4), .STAGES(1), .MODE(cnt_pkg::MOD_RELOAD), .MODULUS(11)) u_rel (
    .clk(clk), .clr(clr), .load(load), .en_p(en_p), .en_t(en_t),
    .din(din[3:0]), .count(cnt_rel), .carry_out(c_rel));

  presettable_counter #(.STAGE_W(4), .STAGES(1), .MODE(cnt_pkg::MOD_DECODE), .MODULUS(11)) u_dec (
    .clk(clk), .clr(clr), .load(load), .en_p(en_p), .en_t(en_t),
    .din(din[3:0]), .count(cnt_dec), .carry_out(c_dec));

  // fields: [20]clr [19]load [18]en_p [17]en_t [16:9]din [8:1]expected count [0]expected carry
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h0D, 8'h0D, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h0E, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h0F, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h10, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'hFE, 8'hFE, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h55, 8'h00, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 12:    return "R1";
      1, 7:     return "R2";
      2, 3, 11: return "R3";
      4, 6:     return "R4";
      5:        return "R6";
      default:  return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic c, logic l, logic p, logic t, logic [7:0] d);
    clr = c; load = l; en_p = p; en_t = t; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] er, ed;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      chk(vec_tag(i), 32'(cnt8), 32'(VEC[i][8:1]));
      chk({vec_tag(i), " carry"}, 32'(c8), 32'(VEC[i][0]));
    end

    // R6: a full 8-bit period through the cascade
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 255; k++) drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R6 count at 255", 32'(cnt8), 32'hFF);
    chk("R6 carry at 255", 32'(c8), 32'h1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R6 wrap after 256", 32'(cnt8), 32'h00);

    // R1: reset state of the modulus builds
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R1 reload build cleared", 32'(cnt_rel), 32'h0);
    chk("R1 decode build cleared", 32'(cnt_dec), 32'h0);

    // R7 / R8: walk both modulus-11 builds against a reference sequence
    er = 4'd0; ed = 4'd0;
    for (int k = 1; k <= 26; k++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      er = (er == 4'd15) ? 4'd5 : er + 4'd1;
      ed = (ed == 4'd10) ? 4'd0 : ed + 4'd1;
      chk("R7 reload sequence", 32'(cnt_rel), 32'(er));
      chk("R8 decode sequence", 32'(cnt_dec), 32'(ed));
      chk("R8 decode carry", 32'(c_dec), 32'(ed == 4'd10));
      chk("R5 reload carry", 32'(c_rel), 32'(er == 4'd15));
    end

    // R9: load at 15 in reload mode beats the preset reload
    chk("R9 reload build at 15", 32'(cnt_rel), 32'hF);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h03);
    chk("R9 reload load wins", 32'(cnt_rel), 32'h3);

    // R9: load at 10 in decode mode beats the decoded clear
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h0A);
    chk("R2 decode preset 10", 32'(cnt_dec), 32'hA);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h07);
    chk("R9 decode load wins", 32'(cnt_dec), 32'h7);

    // R4: hold in decode mode at its last state
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h0A);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R4 decode hold at 10", 32'(cnt_dec), 32'hA);
    chk("R8 carry with en_t", 32'(c_dec), 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule